// File: doc/BRIEF.md
# Radix-4 Mux-Recoded Multiplier

This block multiplies two unsigned operands of even width N (8 by default) and returns the full 2N-bit product. It reads the multiplier two bits at a time. Each bit pair drives a four-way multiplexer, and that multiplexer emits one partial-product row. The row is zero, the multiplicand A, 2A or 3A. A single adder computes the 3A term once, and every row multiplexer shares it. An N-bit multiplier therefore produces N/2 rows, where a bit-per-row AND array would produce N rows.

Row i carries a weight of 4^i. A carry-save tree of 3:2 compressors reduces the shifted rows to one sum row and one carry row. A carry-select adder then adds those two rows. The product goes into a register that clears synchronously, so a new operand pair can enter on every clock, and each result appears one cycle after its operands.

Top module: `mux_recoded_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod_o` becomes zero on that edge, whatever the operands are.
- R2: A multiplier bit pair of value 00 makes its partial-product row zero.
- R3: A multiplier bit pair of value 01 makes its row equal to the multiplicand.
- R4: A multiplier bit pair of value 10 makes its row equal to the multiplicand shifted left by one position (2A).
- R5: A multiplier bit pair of value 11 makes its row equal to A plus 2A (3A), taken from one shared adder.
- R6: The row selected by multiplier bits [2i+1:2i] is weighted by 4^i, so the product is the unsigned product of the two operands for every operand pair.
- R7: The carry-save tree reduces the rows to two rows whose sum equals the product. The final carry-select adder never carries out of bit 2N-1.
- R8: `prod_o` shows the product of the operands sampled at the previous rising edge, and a new operand pair is accepted on every cycle.
- R9: Extreme operands give exact results: either operand zero gives 0, and 255 × 255 gives 65025 at the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the product register |
| mcand_i | input | N | Unsigned multiplicand |
| mplier_i | input | N | Unsigned multiplier, consumed as N/2 bit pairs |
| prod_o | output | 2N | Registered unsigned product |

## Verification
On every clock, the assertions compare each multiplexed row with the multiplicand scaled by its own bit pair. They also check that the shared 3A term is correct, that the carry-save pair adds up to the product, that the final adder has no carry out, that the register follows the previous inputs, and that reset clears it. The bench scenarios cover what the assertions cannot show on their own. These are the full 8×8 operand space driven back to back, multiplier words made entirely of one bit-pair code, and a reset applied in the middle of a run.

// File: rtl/mux_mul_pkg.sv
package mux_mul_pkg;
  // Row choice made by one multiplier bit pair.
  typedef enum logic [1:0] {
    PP_ZERO  = 2'b00,
    PP_ONE   = 2'b01,
    PP_TWO   = 2'b10,
    PP_THREE = 2'b11
  } pp_sel_e;
endpackage

// File: rtl/mmul_pp_row.sv
module mmul_pp_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] mcand_i,
  input  logic [W+1:0] triple_i,
  input  logic [1:0]   sel_i,
  output logic [W+1:0] row_o
);
  import mux_mul_pkg::*;

  pp_sel_e sel;
  assign sel = pp_sel_e'(sel_i);

  always_comb begin
    case (sel)
      PP_ZERO: row_o = '0;
      PP_ONE:  row_o = {2'b00, mcand_i};
      PP_TWO:  row_o = {1'b0, mcand_i, 1'b0};
      default: row_o = triple_i;
    endcase
  end
endmodule

// File: rtl/mmul_csa_tree.sv
module mmul_csa_tree #(
  parameter int W    = 16,
  parameter int ROWS = 4
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int STG = (ROWS > 2) ? ROWS - 2 : 1;

  generate
    if (ROWS == 1) begin : g_one
      assign sum_o   = rows_i[0];
      assign carry_o = '0;
    end else if (ROWS == 2) begin : g_two
      assign sum_o   = rows_i[0];
      assign carry_o = rows_i[1];
    end else begin : g_tree
      logic [STG-1:0][W-1:0] s_l, c_l;
      for (genvar k = 0; k < STG; k++) begin : g_stage
        logic [W-1:0] x, y, z;
        if (k == 0) begin : g_first
          assign x = rows_i[0];
          assign y = rows_i[1];
          assign z = rows_i[2];
        end else begin : g_next
          assign x = s_l[k-1];
          assign y = c_l[k-1];
          assign z = rows_i[k+2];
        end
        // 3:2 compression: the weight of the carry doubles, so it moves up one bit
        assign s_l[k] = x ^ y ^ z;
        assign c_l[k] = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                         (y[W-2:0] & z[W-2:0]), 1'b0};
      end
      assign sum_o   = s_l[STG-1];
      assign carry_o = c_l[STG-1];
    end
  endgenerate
endmodule

// File: rtl/mmul_csel_add.sv
module mmul_csel_add #(
  parameter int W   = 16,
  parameter int BLK = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  localparam int NB = W / BLK;

  logic [NB:0] cy;
  assign cy[0] = 1'b0;

  generate
    for (genvar j = 0; j < NB; j++) begin : g_blk
      logic [BLK:0] r0, r1;
      // both carry-in cases prepared, the incoming carry picks one
      assign r0 = {1'b0, a_i[j*BLK +: BLK]} + {1'b0, b_i[j*BLK +: BLK]};
      assign r1 = {1'b0, a_i[j*BLK +: BLK]} + {1'b0, b_i[j*BLK +: BLK]} + {{BLK{1'b0}}, 1'b1};
      assign sum_o[j*BLK +: BLK] = cy[j] ? r1[BLK-1:0] : r0[BLK-1:0];
      assign cy[j+1]             = cy[j] ? r1[BLK]     : r0[BLK];
    end
  endgenerate

  assign co_o = cy[NB];
endmodule

// File: rtl/mux_recoded_mult.sv
module mux_recoded_mult #(
  parameter int N   = 8,
  parameter int BLK = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] prod_o
);
  localparam int ROWS = N / 2;
  localparam int ROWW = N + 2;
  localparam int PW   = 2 * N;

  logic [ROWW-1:0]           triple_w;
  logic [ROWS-1:0][ROWW-1:0] pp_row;
  logic [ROWS-1:0][PW-1:0]   pp_shf;
  logic [PW-1:0]             csa_sum, csa_carry, sum_w;
  logic                      co_w;
  logic [PW-1:0]             prod_q;

  // one shared 3A term: A + 2A
  assign triple_w = {2'b00, mcand_i} + {1'b0, mcand_i, 1'b0};

  generate
    for (genvar i = 0; i < ROWS; i++) begin : g_row
      mmul_pp_row #(.W(N)) row_i (
        .mcand_i  (mcand_i),
        .triple_i (triple_w),
        .sel_i    (mplier_i[2*i +: 2]),
        .row_o    (pp_row[i])
      );
      assign pp_shf[i] = PW'(pp_row[i]) << (2 * i);

      // R2 R3 R4 R5
      rows_sel_chk: assert property (@(posedge clk) disable iff (rst)
        pp_row[i] == ({2'b00, mcand_i} * {{N{1'b0}}, mplier_i[2*i +: 2]}));
    end
  endgenerate

  mmul_csa_tree #(.W(PW), .ROWS(ROWS)) tree_i (
    .rows_i  (pp_shf),
    .sum_o   (csa_sum),
    .carry_o (csa_carry)
  );

  mmul_csel_add #(.W(PW), .BLK(BLK)) add_i (
    .a_i   (csa_sum),
    .b_i   (csa_carry),
    .sum_o (sum_w),
    .co_o  (co_w)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= sum_w;
  end

  assign prod_o = prod_q;

  // R5
  triple_val_chk: assert property (@(posedge clk) disable iff (rst)
    PW'(triple_w) == PW'(mcand_i) * PW'(3));

  // R7
  csa_pair_chk: assert property (@(posedge clk) disable iff (rst)
    PW'(csa_sum + csa_carry) == PW'(mcand_i) * PW'(mplier_i));

  // R7
  no_carry_out_chk: assert property (@(posedge clk) disable iff (rst) !co_w);

  // R8
  prod_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod_o == $past(PW'(mcand_i) * PW'(mplier_i)));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> prod_o == '0);
endmodule

// File: tb/mux_recoded_mult_tb.sv
module mux_recoded_mult_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic [2*N-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2*N-1:0] exp_q;
  logic [N-1:0]   a_q, b_q;
  string          tag_q;
  bit             pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_recoded_mult #(.N(N)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .prod_o   (prod)
  );

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) acc = acc + ({{N{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic check(input logic [2*N-1:0] act, input logic [2*N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d product %0d expected %0d", tag, a_q, b_q, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
    @(negedge clk);
    if (pend) check(prod, exp_q, tag_q);
    mcand = a; mplier = b;
    a_q = a; b_q = b; exp_q = ref_mul(a, b); tag_q = tag; pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check(prod, exp_q, tag_q);
    pend = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    logic [N-1:0] dir_a [6] = '{8'd1, 8'd2, 8'd37, 8'd128, 8'd201, 8'd255};
    void'($urandom(32'd20240611));
    mcand = 8'hC3; mplier = 8'h5A;
    repeat (3) @(negedge clk);
    a_q = mcand; b_q = mplier;
    check(prod, '0, "R1 reset");
    rst = 1'b0;

    // one bit-pair code repeated across the whole multiplier word
    foreach (dir_a[k]) begin
      step(dir_a[k], 8'h00, "R2 pairs 00");
      step(dir_a[k], 8'h55, "R3 pairs 01");
      step(dir_a[k], 8'hAA, "R4 pairs 10");
      step(dir_a[k], 8'hFF, "R5 pairs 11");
      step(dir_a[k], 8'h1B, "R6 mixed pairs");
    end
    step(8'd0,   8'd0,   "R9 zero");
    step(8'd0,   8'd255, "R9 zero mcand");
    step(8'd255, 8'd0,   "R9 zero mplier");
    step(8'd255, 8'd255, "R9 max");
    flush();

    // reset in the middle of a run
    step(8'd200, 8'd199, "R8 before reset");
    flush();
    mcand = 8'd77; mplier = 8'd91;
    a_q = mcand; b_q = mplier;
    rst = 1'b1;
    @(negedge clk);
    check(prod, '0, "R1 mid-run reset");
    rst = 1'b0;

    // all operand pairs, one new pair per cycle
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(N'(a), N'(b), "R6,R7,R8 exhaustive");
    flush();

    // random back-to-back traffic
    for (int r = 0; r < 3000; r++)
      step(N'($urandom), N'($urandom), "R8 random");
    flush();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      summary();
      $finish;
    end
  end
endmodule